// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is one bank of general-purpose pins, up to 32 of them, controlled through a plain 32-bit register port. Each pin has four control bits: an output value, a direction, a blink enable and an input inversion. A pin configured as an output drives its output bit. When its blink bit is set, that value is inverted on a free-running square wave. Every pin input passes through a synchronizer and then the inversion stage. The result feeds both the readable input register and the interrupt logic.

Each pin can request an interrupt in two ways. The level path is live, with no latch: the adjusted input ANDed with a level enable. The edge path latches a cause bit on every 0-to-1 transition of the adjusted input. Software clears a cause bit by writing zero to it, and the bit reaches the interrupt logic only when its edge enable is set. The pending requests of each group of eight consecutive pins are ORed onto one of four summary interrupt lines. A processor-side handler reads the cause and input registers to find the source.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset all pins are inputs: the direction register reads all ones in the implemented pins, and pin_oe is all zero. Every other register reads zero, pin inputs are low, and irq_sum is zero.
- R2: The direction register is at offset 0x04 and the output register at offset 0x00. A direction bit of 1 disables that pin's driver (pin_oe bit 0). A direction bit of 0 sets pin_oe and places the output bit on pin_out; pin_out carries the output bit for input pins too.
- R3: The input register at offset 0x10 returns the synchronized pin value XOR the inversion bit from offset 0x0C. A pin change driven between two clock edges becomes visible after the second following rising edge, and not after the first.
- R4: The level request of a pin equals its adjusted input AND its level enable bit (offset 0x1C). It holds no state: when the adjusted input drops, the request drops with it.
- R5: A cause bit (offset 0x14) sets when the adjusted input goes from 0 to 1. With inversion 0 this catches a rising pin; with inversion 1 it catches a falling pin. The bit stays set after the input returns.
- R6: A write to offset 0x14 clears every cause bit written as 0 and keeps every bit written as 1.
- R7: If an edge sets a cause bit on the same clock edge as a write that clears it, the bit ends up set.
- R8: A pin is pending when its level request is active or its cause bit AND edge enable bit (offset 0x18) are both set. irq_sum[g] is the OR of the pending bits of pins 8g to 8g+7.
- R9: Register bits for pins at or above NPINS read as zero, and those pins never raise irq_sum, even after all-ones writes.
- R10: For an output pin with its blink bit (offset 0x08) set, pin_out is the output bit XOR a square wave that toggles every BLINK_HALF cycles. With the blink bit clear, pin_out stays constant while the registers are unchanged.
- R11: Writes to the input register at offset 0x10 are ignored and change no other register. Bits 4:2 of the address select the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Pin output values |
| pin_oe | output | NPINS | Pin output enables, 1 drives the pin |
| irq_sum | output | 4 | Summary interrupts, one per group of eight pins |

## Verification
A wrong cause bit appears at the ports in two places. It shows at offset 0x14 on the cycle after the faulty edge. It also shows on the group's summary line whenever the edge enable is set. A stale synchronizer or edge-history flop shifts the cycle in which the input register and the cause change, so the bench samples at exact cycle counts after each pin change. A blink counter with the wrong limit shows as an output toggle interval other than BLINK_HALF. The bench measures that interval directly.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int MAX_PINS = 32;
   localparam int GRP_SIZE = 8;
   localparam int NUM_GRPS = MAX_PINS / GRP_SIZE;
   localparam int BUS_W    = 32;
   localparam int ADDR_W   = 5;

   // register index taken from address bits 4:2
   typedef enum logic [2:0] {
      RI_OUT   = 3'd0,
      RI_DIR   = 3'd1,
      RI_BLINK = 3'd2,
      RI_INV   = 3'd3,
      RI_DIN   = 3'd4,
      RI_CAUSE = 3'd5,
      RI_EDGEN = 3'd6,
      RI_LVLEN = 3'd7
   } reg_idx_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] chain_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
            end else begin
               chain_q[0] <= d;
               for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
            end
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
   parameter int HALF = 1024
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase
);
   generate
      if (HALF == 1) begin : g_every_cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) phase <= 1'b0;
            else        phase <= ~phase;
         end
      end else begin : g_counted
         localparam int CW = $clog2(HALF);
         localparam logic [CW-1:0] LAST = CW'(HALF - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               phase <= 1'b0;
            end else if (cnt_q == LAST) begin
               cnt_q <= '0;
               phase <= ~phase;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core
   import gpio_bank_pkg::*;
#(
   parameter int NPINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NPINS-1:0]    din,
   input  logic                clr_en,
   input  logic [NPINS-1:0]    clr_keep,
   input  logic [NPINS-1:0]    edge_en,
   input  logic [NPINS-1:0]    lvl_en,
   output logic [NPINS-1:0]    cause_q,
   output logic [NPINS-1:0]    edge_hit,
   output logic [NUM_GRPS-1:0] irq_sum
);
   logic [NPINS-1:0]    prev_q;
   logic [NPINS-1:0]    cause_d;
   logic [NPINS-1:0]    pending;
   logic [MAX_PINS-1:0] pend_w;

   assign edge_hit = din & ~prev_q;

   always_comb begin
      cause_d = cause_q;
      if (clr_en) cause_d = cause_d & clr_keep;
      cause_d = cause_d | edge_hit;   // a new edge outranks the clear
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         cause_q <= '0;
      end else begin
         prev_q  <= din;
         cause_q <= cause_d;
      end
   end

   assign pending = (din & lvl_en) | (cause_q & edge_en);

   generate
      for (genvar i = 0; i < MAX_PINS; i++) begin : g_widen
         if (i < NPINS) begin : g_live
            assign pend_w[i] = pending[i];
         end else begin : g_absent
            assign pend_w[i] = 1'b0;
         end
      end
      for (genvar g = 0; g < NUM_GRPS; g++) begin : g_group
         assign irq_sum[g] = |pend_w[g*GRP_SIZE +: GRP_SIZE];
      end
   endgenerate
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int SYNC_STAGES = 2,
   parameter int BLINK_HALF  = 1048576
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wen,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [BUS_W-1:0]    reg_wdata,
   output logic [BUS_W-1:0]    reg_rdata,
   input  logic [NPINS-1:0]    pin_in,
   output logic [NPINS-1:0]    pin_out,
   output logic [NPINS-1:0]    pin_oe,
   output logic [NUM_GRPS-1:0] irq_sum
);
   generate
      if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_npins
         $error("gpio_irq_bank: NPINS must lie in 1..32");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("gpio_irq_bank: SYNC_STAGES must lie in 0..4");
      end
      if (BLINK_HALF < 1) begin : g_bad_blink
         $error("gpio_irq_bank: BLINK_HALF must be at least 1");
      end
   endgenerate

   logic [NPINS-1:0] out_q, dir_q, blink_q, inv_q, edge_en_q, lvl_en_q;
   logic [NPINS-1:0] sync_q, din, cause_q, edge_hit, wdata_n;
   logic             blink_ph, clr_en;
   reg_idx_e         idx;

   assign idx     = reg_idx_e'(reg_addr[4:2]);
   assign wdata_n = reg_wdata[NPINS-1:0];
   assign clr_en  = reg_wen && (idx == RI_CAUSE);

   wire unused_bits = ^{reg_addr[1:0], reg_wdata};

   function automatic logic [BUS_W-1:0] widen(input logic [NPINS-1:0] v);
      logic [BUS_W-1:0] r;
      r = '0;
      r[NPINS-1:0] = v;
      return r;
   endfunction

   // control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q     <= '0;
         dir_q     <= '1;
         blink_q   <= '0;
         inv_q     <= '0;
         edge_en_q <= '0;
         lvl_en_q  <= '0;
      end else if (reg_wen) begin
         case (idx)
            RI_OUT:   out_q     <= wdata_n;
            RI_DIR:   dir_q     <= wdata_n;
            RI_BLINK: blink_q   <= wdata_n;
            RI_INV:   inv_q     <= wdata_n;
            RI_EDGEN: edge_en_q <= wdata_n;
            RI_LVLEN: lvl_en_q  <= wdata_n;
            default: ;   // input and cause handled elsewhere
         endcase
      end
   end

   gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (sync_q)
   );

   assign din = sync_q ^ inv_q;

   gpio_blink_gen #(.HALF(BLINK_HALF)) i_blink (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (blink_ph)
   );

   gpio_irq_core #(.NPINS(NPINS)) i_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (din),
      .clr_en   (clr_en),
      .clr_keep (wdata_n),
      .edge_en  (edge_en_q),
      .lvl_en   (lvl_en_q),
      .cause_q  (cause_q),
      .edge_hit (edge_hit),
      .irq_sum  (irq_sum)
   );

   assign pin_oe  = ~dir_q;
   assign pin_out = out_q ^ (blink_q & ~dir_q & {NPINS{blink_ph}});

   always_comb begin
      case (idx)
         RI_OUT:   reg_rdata = widen(out_q);
         RI_DIR:   reg_rdata = widen(dir_q);
         RI_BLINK: reg_rdata = widen(blink_q);
         RI_INV:   reg_rdata = widen(inv_q);
         RI_DIN:   reg_rdata = widen(din);
         RI_CAUSE: reg_rdata = widen(cause_q);
         RI_EDGEN: reg_rdata = widen(edge_en_q);
         default:  reg_rdata = widen(lvl_en_q);
      endcase
   end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int NPINS = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wen,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [BUS_W-1:0]    reg_wdata,
   input logic [NPINS-1:0]    pin_out,
   input logic [NPINS-1:0]    pin_oe,
   input logic [NUM_GRPS-1:0] irq_sum,
   input logic [NPINS-1:0]    cause_q,
   input logic [NPINS-1:0]    edge_hit,
   input logic [NPINS-1:0]    blink_q,
   input logic [NPINS-1:0]    edge_en_q,
   input logic [NPINS-1:0]    lvl_en_q
);
   // R2: a direction write shows on the enables one cycle later
   p_dir_to_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && reg_addr[4:2] == 3'd1) |=> (pin_oe == ~$past(reg_wdata[NPINS-1:0])));

   // R5: a cause bit only rises where an edge was seen
   p_cause_needs_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_q & ~$past(cause_q) & ~$past(edge_hit)) == '0));

   // R6: bits written as zero are clear afterwards unless an edge arrived
   p_cause_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && reg_addr[4:2] == 3'd5) |=>
      ((cause_q & ~$past(reg_wdata[NPINS-1:0]) & ~$past(edge_hit)) == '0));

   // R7: a detected edge always lands in the cause register
   p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|edge_hit) |=> ((cause_q & $past(edge_hit)) == $past(edge_hit)));

   // R8: nothing enabled means no summary interrupt
   p_quiet_when_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_en_q == '0 && lvl_en_q == '0) |-> (irq_sum == '0));

   // R10: without blink and without writes the outputs hold
   p_no_blink_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (blink_q == '0 && !reg_wen) |=> $stable(pin_out));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wen   (reg_wen),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq_sum   (irq_sum),
   .cause_q   (cause_q),
   .edge_hit  (edge_hit),
   .blink_q   (blink_q),
   .edge_en_q (edge_en_q),
   .lvl_en_q  (lvl_en_q)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
   localparam int NP   = 12;
   localparam int HALF = 4;
   localparam logic [31:0] MSK = 32'h0000_0FFF;
   localparam logic [4:0] A_OUT = 5'h00, A_DIR = 5'h04, A_BLK = 5'h08, A_INV = 5'h0C;
   localparam logic [4:0] A_DIN = 5'h10, A_CAU = 5'h14, A_EEN = 5'h18, A_LEN = 5'h1C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wen = 1'b0;
   logic [4:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   wire  [31:0]   reg_rdata;
   logic [NP-1:0] pin_in = '0;
   wire  [NP-1:0] pin_out, pin_oe;
   wire  [3:0]    irq_sum;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gpio_irq_bank #(.NPINS(NP), .SYNC_STAGES(2), .BLINK_HALF(HALF)) i_gpio_irq_bank (
      .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq_sum(irq_sum)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [3:0] groups(input logic [31:0] pend);
      logic [3:0] r;
      for (int g = 0; g < 4; g++) r[g] = |pend[g*8 +: 8];
      return r;
   endfunction

   initial begin
      #(8 * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, e;
      logic [31:0] pins_l [4];
      logic [31:0] inv_l  [3];
      logic [31:0] dir_l  [4];
      logic [31:0] smp    [20];
      logic [4:0]  addr_l [8];
      pins_l = '{32'h000, 32'hFFF, 32'hA5C, 32'h3C3};
      inv_l  = '{32'h000, 32'hFFF, 32'h0F0};
      dir_l  = '{32'h000, 32'hFFF, 32'h555, 32'h0F3};
      addr_l = '{A_OUT, A_DIR, A_BLK, A_INV, A_DIN, A_CAU, A_EEN, A_LEN};

      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      for (int k = 0; k < 8; k++) begin
         rd(addr_l[k], v);
         e = (addr_l[k] == A_DIR) ? MSK : 32'h0;
         chk(v == e, "R1 register after reset", v, e);
      end
      chk(pin_oe == '0, "R1 pin_oe after reset", 32'(pin_oe), 0);
      chk(irq_sum == '0, "R1 irq_sum after reset", 32'(irq_sum), 0);

      // R2 direction and output sweep
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 2; b++) begin
            e = (b == 0) ? 32'hFFF : 32'h6A9;
            wr(A_DIR, dir_l[a]);
            wr(A_OUT, e);
            chk(32'(pin_oe) == (~dir_l[a] & MSK), "R2 pin_oe", 32'(pin_oe), ~dir_l[a] & MSK);
            chk(32'(pin_out) == e, "R2 pin_out", 32'(pin_out), e);
         end
      end
      wr(A_DIR, MSK);
      wr(A_OUT, 0);

      // R3 input register sweep
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 3; b++) begin
            wr(A_INV, inv_l[b]);
            pin_in = NP'(pins_l[a]);
            cyc(2);
            rd(A_DIN, v);
            e = pins_l[a] ^ inv_l[b];
            chk(v == e, "R3 input register", v, e);
         end
      end
      // R3 exact latency
      wr(A_INV, 0);
      pin_in = '0;
      cyc(3);
      pin_in = 12'h081;
      cyc(1);
      rd(A_DIN, v);
      chk(v == 32'h0, "R3 not visible after one edge", v, 0);
      cyc(1);
      rd(A_DIN, v);
      chk(v == 32'h081, "R3 visible after two edges", v, 32'h081);

      // R11 input register is read-only
      wr(A_OUT, 32'h0A5);
      wr(A_DIN, 32'hFFF);
      rd(A_DIN, v);
      chk(v == 32'h081, "R11 input write ignored", v, 32'h081);
      rd(A_OUT, v);
      chk(v == 32'h0A5, "R11 other register untouched", v, 32'h0A5);
      wr(A_OUT, 0);

      // R4 and R8 level sweep per pin
      pin_in = '0;
      wr(A_EEN, 0);
      cyc(3);
      wr(A_CAU, 0);
      for (int p = 0; p < NP; p++) begin
         wr(A_LEN, 32'h1 << p);
         pin_in = NP'(32'h1 << p);
         cyc(2);
         e = 32'(groups(32'h1 << p));
         chk(32'(irq_sum) == e, "R4 level request raises group", 32'(irq_sum), e);
         pin_in = '0;
         cyc(2);
         chk(irq_sum == '0, "R4 level request drops without latch", 32'(irq_sum), 0);
      end
      // R8 group OR with several pins and inversion
      wr(A_LEN, MSK);
      wr(A_INV, 32'h100);
      cyc(1);
      chk(irq_sum == 4'b0010, "R8 group one via inverted pin", 32'(irq_sum), 32'h2);
      wr(A_INV, 0);
      wr(A_LEN, 0);
      cyc(3);
      wr(A_CAU, 0);

      // R5 R6 R8 edge sweep, even pins rising, odd pins falling
      wr(A_EEN, MSK);
      for (int p = 0; p < NP; p++) begin
         logic [31:0] pb;
         pb = 32'h1 << p;
         pin_in = (p % 2 == 1) ? NP'(pb) : '0;
         wr(A_INV, (p % 2 == 1) ? pb : 0);
         cyc(3);
         wr(A_CAU, 0);
         rd(A_CAU, v);
         chk(v == 0, "R5 idle leaves cause clear", v, 0);
         pin_in = pin_in ^ NP'(pb);
         cyc(3);
         rd(A_CAU, v);
         chk(v == pb, "R5 active edge sets cause", v, pb);
         e = 32'(groups(pb));
         chk(32'(irq_sum) == e, "R8 edge raises group", 32'(irq_sum), e);
         pin_in = pin_in ^ NP'(pb);
         cyc(3);
         rd(A_CAU, v);
         chk(v == pb, "R5 cause held after return", v, pb);
         wr(A_CAU, MSK);
         rd(A_CAU, v);
         chk(v == pb, "R6 ones keep cause", v, pb);
         wr(A_EEN, 0);
         chk(irq_sum == '0, "R8 edge enable gates cause", 32'(irq_sum), 0);
         wr(A_EEN, MSK);
         wr(A_CAU, MSK & ~pb);
         rd(A_CAU, v);
         chk(v == 0, "R6 zero clears cause", v, 0);
         chk(irq_sum == '0, "R6 cleared cause quiet", 32'(irq_sum), 0);
      end

      // R6 mixed keep pattern
      wr(A_INV, 0);
      pin_in = '0;
      cyc(3);
      wr(A_CAU, 0);
      pin_in = 12'hA5C;
      cyc(3);
      wr(A_CAU, 32'h0F0);
      rd(A_CAU, v);
      chk(v == 32'h050, "R6 partial clear", v, 32'h050);

      // R7 set wins over clear on the same edge
      pin_in = pin_in | 12'h001;
      cyc(2);
      wr(A_CAU, 0);
      rd(A_CAU, v);
      chk(v == 32'h001, "R7 edge beats clear", v, 32'h001);
      wr(A_CAU, 0);

      // R9 absent pins
      for (int k = 0; k < 8; k++) begin
         if (addr_l[k] != A_DIN && addr_l[k] != A_CAU) begin
            wr(addr_l[k], 32'hFFFF_FFFF);
            rd(addr_l[k], v);
            chk(v == MSK, "R9 upper bits read zero", v, MSK);
         end
      end
      chk(irq_sum[3:2] == 2'b00, "R9 upper groups quiet", 32'(irq_sum), 0);
      wr(A_LEN, 0);
      wr(A_EEN, 0);
      wr(A_INV, 0);
      wr(A_BLK, 0);

      // R10 blink
      wr(A_DIR, 32'hFFC);
      wr(A_OUT, 32'h002);
      wr(A_BLK, 32'h003);
      for (int s = 0; s < 20; s++) begin
         smp[s] = 32'(pin_out);
         cyc(1);
      end
      begin
         int first, errs;
         first = -1;
         errs = 0;
         for (int s = 1; s < 20; s++)
            if (first < 0 && smp[s] != smp[s-1]) first = s;
         for (int s = 1; s < 20; s++) begin
            if (first >= 0 && s > first) begin
               if ((smp[s] != smp[s-1]) != ((s - first) % HALF == 0)) errs++;
            end
            if ((smp[s][0] ^ smp[s][1]) != 1'b1) errs++;
            if (smp[s][11:2] != '0) errs++;
         end
         chk(first > 0 && first <= HALF, "R10 blink starts toggling", 32'(first), HALF);
         chk(errs == 0, "R10 blink interval and phase", 32'(errs), 0);
      end
      wr(A_BLK, 0);
      v = 32'(pin_out);
      cyc(2 * HALF + 1);
      chk(32'(pin_out) == v, "R10 steady without blink", 32'(pin_out), v);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule